// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address for each beat of a four-beat burst that wraps within an aligned group of four. A load strobe captures a full start address. After that, each cycle in which the active-low advance input is held low steps the two low address bits to the next beat. The ordering is either linear, where the two bits count up modulo four, or interleaved, where the two bits are the start bits XOR-ed with the beat number. A mode input selects the ordering, and it is sampled when the burst is loaded.

The upper address bits are taken from the start address at load time and are never changed by advancing. The output is registered, so each change shows on `word_addr_o` one clock after the edge that caused it. Read bursts and write bursts use the same sequencing.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `word_addr_o` becomes all zeros after that edge.
- R2: When `load_i` is 1 at an edge, `word_addr_o` equals `start_addr_i` after that edge. Bit 0 is the LSB, and `[BEAT_W-1:0]` are the beat bits.
- R3: When `load_i` is 1, a low `adv_n_i` in the same cycle has no effect: the output is exactly `start_addr_i`.
- R4: When `load_i` is 0 and `adv_n_i` is 1 at an edge, `word_addr_o` is unchanged.
- R5: In linear order (mode value 0 at load), each advance sets the beat bits to (start + k) mod 4, where k is the number of advances since the load.
- R6: In interleaved order (mode value 1 at load), each advance sets the beat bits to start XOR (k mod 4).
- R7: `mode_i` is only sampled on load cycles. Changing it during a burst does not alter the sequence.
- R8: Advancing never modifies `word_addr_o[ADDR_W-1:BEAT_W]`, and `start_addr_i` is ignored when `load_i` is 0.
- R9: In both orders, four advances after a load return `word_addr_o` to the loaded start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a burst by capturing `start_addr_i` |
| start_addr_i | input | ADDR_W | Full start word address of the burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Ordering select: 0 linear, 1 interleaved |
| word_addr_o | output | ADDR_W | Registered current word address |

## Verification
The captured start bits, beat counter and latched mode are not visible at the ports. Any error in them shows up in the beat bits of `word_addr_o` one clock after the advance or load that went wrong.

A beat counter that fails to clear on load is caught on the first advance after the next load. A mode latched at the wrong time is caught on the first advance after `mode_i` is toggled mid-burst. A broken wrap is caught on the fourth advance, which must land back on the start address.

Corruption of the upper bits is caught on the very next clock, because those bits must stay fixed across advances.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
// Beat index counter: cleared by a load, stepped by an advance.
// Exposes both the registered value and the value it takes at the next edge.
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  always_comb begin
    if (load)     beat_nxt = '0;
    else if (adv) beat_nxt = beat_q + 1'b1;
    else          beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bseq_order_map.sv
// Maps the start bits and a beat index onto the beat address bits.
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  // The sum is truncated to BEAT_W bits, which gives the wrap.
  assign lin_low = start + beat;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_xor
      assign xor_low[b] = start[b] ^ beat[b];
    end
  endgenerate

  assign low = (order == ORDER_XOR) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] word_addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0]  start_q, start_nxt;
  logic [BEAT_W-1:0]  beat_q, beat_nxt;
  logic [BEAT_W-1:0]  low_nxt;
  logic [UPPER_W-1:0] upper_nxt;
  order_e             order_q, order_nxt;
  logic               adv;
  logic [ADDR_W-1:0]  word_q;

  assign adv = ~adv_n_i;

  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .adv      (adv),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  // Start bits, upper bits and ordering are captured only on a load.
  always_comb begin
    if (load_i) begin
      start_nxt = start_addr_i[BEAT_W-1:0];
      upper_nxt = start_addr_i[ADDR_W-1:BEAT_W];
      order_nxt = order_e'(mode_i);
    end else begin
      start_nxt = start_q;
      upper_nxt = word_q[ADDR_W-1:BEAT_W];
      order_nxt = order_q;
    end
  end

  bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start (start_nxt),
    .beat  (beat_nxt),
    .order (order_nxt),
    .low   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      order_q <= ORDER_LINEAR;
      word_q  <= '0;
    end else begin
      start_q <= start_nxt;
      order_q <= order_nxt;
      word_q  <= {upper_nxt, low_nxt};
    end
  end

  assign word_addr_o = word_q;

  // beat_q only feeds back into the counter's own next-state logic.
  logic unused_beat;
  assign unused_beat = ^beat_q;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              adv_n_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] word_addr_o
);
  // Ordering seen at the last load, observed from the ports only.
  logic mode_seen;
  always_ff @(posedge clk) begin
    if (rst)         mode_seen <= 1'b0;
    else if (load_i) mode_seen <= mode_i;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> word_addr_o == '0); // R1

  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    load_i |=> word_addr_o == $past(start_addr_i)); // R2

  AST_LOAD_BEATS_ADV: assert property (@(posedge clk) disable iff (rst)
    (load_i && !adv_n_i) |=> word_addr_o == $past(start_addr_i)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(word_addr_o)); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !mode_seen) |=>
      word_addr_o[BEAT_W-1:0] == BEAT_W'($past(word_addr_o[BEAT_W-1:0]) + 1'b1)); // R5

  AST_XOR_STEP_TOGGLES_LSB: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && mode_seen) |=>
      word_addr_o[0] != $past(word_addr_o[0])); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> word_addr_o[ADDR_W-1:BEAT_W] == $past(word_addr_o[ADDR_W-1:BEAT_W])); // R8
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 6;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] start_addr_i;
  logic          adv_n_i;
  logic          mode_i;
  logic [AW-1:0] word_addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .word_addr_o  (word_addr_o)
  );

  // Drive inputs for one cycle, then sample 1 ns after the rising edge.
  task automatic step(input logic ld, input logic [AW-1:0] a,
                      input logic advn, input logic md);
    load_i = ld; start_addr_i = a; adv_n_i = advn; mode_i = md;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (word_addr_o !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, word_addr_o, exp);
    end
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] a,
                                                input int k, input logic md);
    int s;
    int lo;
    s  = int'(a[BW-1:0]);
    lo = md ? (s ^ (k % 4)) : ((s + k) % 4);
    return {a[AW-1:BW], BW'(lo)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; load_i = 1'b0; start_addr_i = '0; adv_n_i = 1'b1; mode_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", '0);
    rst = 1'b0;

    // Sweep every upper value, start value and ordering.
    for (int up = 0; up < (1 << (AW - BW)); up++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m < 2; m++) begin
          logic [AW-1:0] a;
          logic [AW-1:0] junk;
          logic md;
          a    = {(AW-BW)'(up), BW'(s)};
          junk = ~a;
          md   = 1'(m);
          step(1'b1, a, 1'b1, md);
          check("R2 load capture", a);
          for (int k = 1; k <= 4; k++) begin
            // mode_i toggles each beat (R7) and start_addr_i carries junk (R8)
            step(1'b0, junk, 1'b0, md ^ 1'(k));
            if (md) check("R6 R7 R8 xor order", expect_addr(a, k, md));
            else    check("R5 R7 R8 linear order", expect_addr(a, k, md));
            if (k == 2) begin
              step(1'b0, junk, 1'b1, ~md);
              check("R4 hold mid burst", expect_addr(a, 2, md));
            end
            if (k == 4) check("R9 wrap to start", a);
          end
          step(1'b0, junk, 1'b1, ~md);
          check("R4 hold after wrap", a);
        end
      end
    end

    // A load with advance in the same cycle starts at beat 0.
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] a;
      a = {(AW-BW)'(s + 5), BW'(s)};
      step(1'b0, a, 1'b0, 1'b0);
      step(1'b1, a, 1'b0, 1'b1);
      check("R3 load beats advance", a);
      step(1'b0, '0, 1'b0, 1'b0);
      check("R3 beat counter cleared", expect_addr(a, 1, 1'b1));
    end

    // A reset in the middle of a burst.
    step(1'b1, 6'h2b, 1'b1, 1'b0);
    step(1'b0, 6'h00, 1'b0, 1'b0);
    rst = 1'b1;
    step(1'b0, 6'h00, 1'b1, 1'b0);
    check("R1 reset mid burst", '0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule